// File: doc/BRIEF.md
# Display Pixel Unpacker with Indexed Colour Lookup

This block sits between a word FIFO of display data and the pixel path of a panel controller. It accepts 32-bit words on a ready/valid input and splits each word into pixels at the bits-per-pixel setting that is selected. The indexed depths are 1, 2, 4 and 8 bits. At those depths each pixel is an index into a 256-entry, 16-bit colour table, and the table entry is what leaves the block. The direct depths are 16 and 24 bits. At those depths the pixel bits pass straight through and the table is not used.

Three orderings of pixels within a word can be selected. The first takes pixels from the least significant end. The second takes them from the most significant end. The third takes bytes from the least significant end but reads the pixels inside each byte starting from the top bit. A separate write port loads the colour table, and it can do so while the stream is running.

Pixels leave on a ready/valid stream that carries a 24-bit value. The table read adds one cycle of latency, and the output valid is delayed to line up with it. When the consumer holds off, the unpacker stalls and no pixel is lost or repeated. The depth and order settings are expected to stay fixed while a word is being unpacked.

Top module: `pix_unpack`

## Requirements
- R1: The depth select `bpp_sel` chooses the pixel width and the number of pixels per word: 0 gives 1 bit (32 pixels), 1 gives 2 bits (16), 2 gives 4 bits (8), 3 gives 8 bits (4), 4 gives 16 bits (2), and 5, 6 or 7 give 24 bits (1). Each accepted word produces exactly that many output pixels.
- R2: With `order_sel` = 0 (or 3), pixel i of a word of width w comes from bits [i*w + w-1 : i*w].
- R3: With `order_sel` = 1, pixel i comes from bits [31 - i*w : 32 - (i+1)*w].
- R4: With `order_sel` = 2 and w below 8, pixel i comes from byte floor(i*w/8), taken from the top of that byte down. With w of 8 or more, the ordering is the same as in R2.
- R5: At the indexed depths, `out_pixel` equals {8'h00, table[index]}, where index is the pixel value zero-extended to 8 bits.
- R6: At 16 bits, `out_pixel` equals {8'h00, pixel}. At 24 bits, `out_pixel` equals word bits 23:0, and bits 31:24 have no effect.
- R7: A table write to an address makes the new value visible to the lookups in the following cycles. A lookup of the same address in the same cycle as the write returns the old value.
- R8: The first pixel of a word that is accepted while the output is idle appears on `out_valid` in the second cycle after the acceptance edge. Valid is raised by the edge that follows the acceptance edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pixel` hold steady. Under any pattern of `out_ready`, the pixel sequence is delivered without loss or duplication.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: With `out_ready` held high and words offered back to back, one pixel is delivered every cycle with no gap, including across word boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bpp_sel | input | 3 | Pixel depth select (see R1) |
| order_sel | input | 2 | Pixel order select (see R2 to R4) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Display data word |
| pal_we | input | 1 | Colour table write enable |
| pal_waddr | input | 8 | Colour table write address |
| pal_wdata | input | 16 | Colour table write data |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | 24 | Colour value or direct pixel |

## Verification
A wrong pixel counter or a wrong shift position corrupts the very next pixel that is delivered. It also corrupts the boundary between words, which shows as an extra or a missing pixel before the next word's first value. A stalled path that lets the table register move shows the altered value in the same cycle the consumer resumes. A word register that fails to release shows as `in_ready` stuck low and a gap in the stream within one word time. The bench sweeps every depth and order, with and without backpressure, and compares each pixel against values computed from the field positions.

// File: rtl/pix_unpack.sv
module pix_unpack #(
  parameter int PAL_AW = 8,
  parameter int PAL_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bpp_sel,
  input  logic [1:0]  order_sel,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  input  logic        pal_we,
  input  logic [7:0]  pal_waddr,
  input  logic [15:0] pal_wdata,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_pixel
);
  localparam int PAL_N = 1 << PAL_AW;

  logic [31:0]      wrd;
  logic             wvld;
  logic [4:0]       idx;
  logic [2:0]       bsel;
  logic [5:0]       npix;
  logic [4:0]       pos_le, xo, pos;
  logic [15:0]      sh;
  logic [23:0]      raw, raw_q;
  logic             dir_q, last, adv;
  logic [PAL_W-1:0] pal [PAL_N];
  logic [PAL_W-1:0] pal_q;

  assign bsel = (bpp_sel > 3'd5) ? 3'd5 : bpp_sel;

  always_comb begin
    case (bsel)
      3'd0: npix = 6'd32;
      3'd1: npix = 6'd16;
      3'd2: npix = 6'd8;
      3'd3: npix = 6'd4;
      3'd4: npix = 6'd2;
      default: npix = 6'd1;
    endcase
  end

  always_comb begin
    pos_le = 5'(idx << bsel);
    xo = 5'd0;
    if (order_sel == 2'd1) begin
      case (bsel)
        3'd0: xo = 5'd31;
        3'd1: xo = 5'd30;
        3'd2: xo = 5'd28;
        3'd3: xo = 5'd24;
        3'd4: xo = 5'd16;
        default: xo = 5'd0;
      endcase
    end else if (order_sel == 2'd2) begin
      case (bsel)
        3'd0: xo = 5'd7;
        3'd1: xo = 5'd6;
        3'd2: xo = 5'd4;
        default: xo = 5'd0;
      endcase
    end
    pos = (bsel == 3'd5) ? 5'd0 : (pos_le ^ xo);
  end

  assign sh = 16'(wrd >> pos);

  always_comb begin
    case (bsel)
      3'd0: raw = {23'd0, sh[0]};
      3'd1: raw = {22'd0, sh[1:0]};
      3'd2: raw = {20'd0, sh[3:0]};
      3'd3: raw = {16'd0, sh[7:0]};
      3'd4: raw = {8'd0, sh};
      default: raw = wrd[23:0];
    endcase
  end

  assign last     = ({1'b0, idx} == npix - 6'd1);
  assign adv      = wvld & (~out_valid | out_ready);
  assign in_ready = ~wvld | (adv & last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wvld <= 1'b0;
      idx  <= '0;
      wrd  <= '0;
    end else begin
      if (adv) begin
        if (last) wvld <= 1'b0;
        else      idx  <= idx + 5'd1;
      end
      if (in_valid && in_ready) begin
        wrd  <= in_word;
        wvld <= 1'b1;
        idx  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      raw_q     <= '0;
      dir_q     <= 1'b0;
    end else if (adv) begin
      out_valid <= 1'b1;
      raw_q     <= raw;
      dir_q     <= (bsel >= 3'd4);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (pal_we) pal[pal_waddr[PAL_AW-1:0]] <= pal_wdata[PAL_W-1:0];
    if (adv)    pal_q <= pal[raw[PAL_AW-1:0]];
  end

  assign out_pixel = dir_q ? raw_q : {{(24-PAL_W){1'b0}}, pal_q};

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel));

  // R8
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(wvld));

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wvld |-> ({1'b0, idx} < npix));

  // R11
  word_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> wvld && idx == 5'd0);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !wvld);
endmodule

// File: tb/sim_pix_unpack.sv
module sim_pix_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bpp_sel = '0;
  logic [1:0]  order_sel = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_waddr = '0;
  logic [15:0] pal_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_pixel;

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1234_5678;

  pix_unpack u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] palv(logic [7:0] a);
    return {a ^ 8'h5A, ~a ^ {a[3:0], a[7:4]}};
  endfunction

  function automatic logic [23:0] expv(logic [31:0] wd, int b, int o, int i);
    int w, lsb;
    logic [31:0] f;
    if (b >= 5) return wd[23:0];
    w = 1 << b;
    if (o == 1)               lsb = 32 - (i + 1) * w;
    else if (o == 2 && w < 8) lsb = ((i * w) / 8) * 8 + 8 - ((i * w) % 8) - w;
    else                      lsb = i * w;
    f = (wd >> lsb) & ((32'd1 << w) - 32'd1);
    if (b == 4) return {8'h00, f[15:0]};
    return {8'h00, palv(f[7:0])};
  endfunction

  task automatic pal_write(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    pal_we = 1'b1; pal_waddr = a; pal_wdata = d;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  task automatic run(int b, int o, bit bp);
    logic [31:0] ws [4];
    int np, total, got, c, cfirst, clast;
    string tag;
    np = (b >= 5) ? 1 : (32 >> b);
    total = 4 * np;
    for (int k = 0; k < 4; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      ws[k] = seed ^ {seed[15:0], seed[31:16]};
    end
    if (b >= 4)      tag = "R6";
    else if (o == 1) tag = "R5 R3";
    else if (o == 2) tag = "R5 R4";
    else             tag = "R5 R2";
    if (bp) tag = {tag, " R9"};
    @(negedge clk);
    bpp_sel = 3'(b); order_sel = 2'(o);
    got = 0; c = 0; cfirst = -1; clast = 0;
    fork
      begin
        for (int k = 0; k < 4; k++) begin
          bit acc = 1'b0;
          while (!acc) begin
            @(negedge clk);
            in_valid = 1'b1; in_word = ws[k];
            #1 acc = in_ready;
            @(posedge clk);
          end
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        while (got < total) begin
          @(negedge clk);
          out_ready = bp ? (c % 3 != 1) : 1'b1;
          #2;
          if (out_valid && out_ready) begin
            logic [23:0] e;
            e = expv(ws[got / np], b, o, got % np);
            chk(out_pixel == e, tag, 32'(out_pixel), 32'(e));
            if (cfirst < 0) cfirst = c;
            clast = c;
            got++;
          end
          c++;
        end
      end
    join
    @(negedge clk);
    out_ready = 1'b1;
    #2;
    // R1: exactly the expected pixel count, nothing further
    chk(!out_valid, "R1", 32'(out_valid), 32'd0);
    // R11: back-to-back delivery without gaps
    if (!bp) chk(clast - cfirst == total - 1, "R11", 32'(clast - cfirst), 32'(total - 1));
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10
    chk(!out_valid, "R10", 32'(out_valid), 32'd0);
    chk(in_ready, "R10", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    // R7: load whole table through the write port
    for (int a = 0; a < 256; a++) pal_write(8'(a), palv(8'(a)));
    for (int b = 0; b < 7; b++)
      for (int o = 0; o < 4; o++)
        for (int bp = 0; bp < 2; bp++)
          run(b, o, bit'(bp));

    // R7 and R8: latency and same-cycle write collision
    @(negedge clk);
    bpp_sel = 3'd3; order_sel = 2'd0; out_ready = 1'b1;
    in_valid = 1'b1; in_word = 32'h3333_3333;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid, "R8", 32'(out_valid), 32'd0);
    pal_we = 1'b1; pal_waddr = 8'h33; pal_wdata = 16'hBEEF;
    @(negedge clk);
    pal_we = 1'b0;
    chk(out_valid, "R8", 32'(out_valid), 32'd1);
    chk(out_pixel == {8'h00, palv(8'h33)}, "R7", 32'(out_pixel), {16'h0, palv(8'h33)});
    @(negedge clk);
    chk(out_valid && out_pixel == 24'h00BEEF, "R7", 32'(out_pixel), 32'h0000BEEF);
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", 32'(out_valid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule